// File: doc/BRIEF.md
# Timer Output Compare Channel

A single timer channel built around an up-counter that runs from zero to a programmed period, wraps to zero and repeats. One compare value and a three-bit mode code decide how a registered reference waveform follows the count: it can be held low, held high, frozen, inverted on every compare match, or driven as an edge-aligned PWM signal whose high time is the compare value. A prescale tick input gates every counter advance, so the channel runs at the clock rate divided by whatever divider produces that tick.

Period and compare values are taken into shadow copies only at a counter wrap, or while the counter is parked. A new duty cycle or period therefore never cuts a running cycle short. A one-pulse option parks the counter at zero until a rising edge on a trigger input. The counter then runs a single cycle from zero to the period, and in PWM mode the output goes active from the compare point to the end of that cycle. An update flag marks each wrap.

Top module: `tmr_oc_channel`

## Requirements
- R1: The counter advances from 0 to the period value inclusive. On the advance that follows the period value it returns to 0. `upd_flag` is high for exactly one clock, starting one clock after that wrap edge, so with a tick on every clock it repeats every period+1 clocks.
- R2: The counter advances only on clocks where `tick_en` is high. With one tick every d clocks, `upd_flag` repeats every (period+1)*d clocks.
- R3: Mode 3'b011 (toggle): `oc_ref` inverts one clock after each counter advance that lands on the compare value.
- R4: Mode 3'b110 (PWM A, one-pulse off): one clock after each counter value is reached, `oc_ref` is 1 if that value is below the compare value and 0 otherwise.
- R5: In PWM A, a compare value of 0 keeps `oc_ref` at 0. A compare value above the period keeps it at 1.
- R6: New period and compare inputs take effect only at a counter wrap, or while a one-pulse counter is parked. Until then the waveform follows the previous values.
- R7: With `one_pulse_en` high, the counter stays at 0 until a rising edge of `trig_in`. It then runs once from 0 to the period and parks again. In PWM A, `oc_ref` is 1 while the running count is at or above the compare value, and it returns to 0 once the cycle ends.
- R8: A trigger edge that arrives while a single cycle is running has no effect. With `one_pulse_en` low, `trig_in` has no effect and the counter runs freely.
- R9: Mode 3'b100 drives `oc_ref` to 0 and mode 3'b101 drives it to 1, one clock after the mode is applied.
- R10: Mode 3'b000 (frozen) and the unused codes 3'b001, 3'b010 and 3'b111 hold `oc_ref` at its present value.
- R11: A synchronous `rst` clears the counter, the shadow period and compare values, the one-pulse running state, `oc_ref` and `upd_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescale tick; counter advances only when high |
| period_in | input | 16 | Period value (last count before wrap) |
| compare_in | input | 16 | Compare value |
| mode_in | input | 3 | Reference output mode code |
| one_pulse_en | input | 1 | Enables trigger-started single-cycle operation |
| trig_in | input | 1 | Trigger; a rising edge starts a single cycle |
| oc_ref | output | 1 | Registered reference waveform |
| upd_flag | output | 1 | One-clock pulse after each counter wrap |

## Verification
Any error in the count or in the shadow values shows up at the ports within one counter cycle. A miscounted counter moves the next `upd_flag` pulse and the PWM edges. A stale or premature shadow load changes the duty of the cycle in which it happens. A wrong one-pulse running state is exposed at the next trigger edge: the pulse either never starts, or it keeps repeating after the period instead of parking. A fault in the toggle state flips the phase of `oc_ref` at the next compare match. Because all of these are registered, each one appears one clock after the faulty edge.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] OCM_FROZEN = 3'b000;
  localparam logic [MODE_W-1:0] OCM_TOGGLE = 3'b011;
  localparam logic [MODE_W-1:0] OCM_LOW    = 3'b100;
  localparam logic [MODE_W-1:0] OCM_HIGH   = 3'b101;
  localparam logic [MODE_W-1:0] OCM_PWMA   = 3'b110;

  // PWM A level for a free-running counter
  function automatic logic pwm_a_level(input logic [15:0] cnt, input logic [15:0] cmp);
    return cnt < cmp;
  endfunction

  // one-pulse level: active from compare to end of the single cycle
  function automatic logic pulse_level(input logic running, input logic [15:0] cnt,
                                       input logic [15:0] cmp);
    return running && (cnt >= cmp);
  endfunction

  // next counter value on an advance
  function automatic logic [15:0] count_next(input logic [15:0] cnt, input logic [15:0] per);
    return (cnt == per) ? 16'd0 : cnt + 16'd1;
  endfunction

endpackage

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] compare_in,
  input  logic             one_pulse_en,
  input  logic             trig_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_sh,
  output logic [CNT_W-1:0] cmp_sh,
  output logic             op_run,
  output logic             step,
  output logic             wrap_q
);

  logic trig_prev;
  logic trig_rise;
  logic run_now;
  logic adv;
  logic wrap;
  logic load_sh;

  assign trig_rise = trig_in & ~trig_prev;
  assign run_now   = ~one_pulse_en | op_run;
  assign adv       = tick_en & run_now;
  assign wrap      = adv & (cnt == per_sh);
  assign load_sh   = wrap | ~run_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      per_sh    <= '0;
      cmp_sh    <= '0;
      op_run    <= 1'b0;
      step      <= 1'b0;
      wrap_q    <= 1'b0;
      trig_prev <= 1'b0;
    end else begin
      trig_prev <= trig_in;
      step      <= adv;
      wrap_q    <= wrap;
      if (adv) begin
        cnt <= wrap ? '0 : cnt + 1'b1;
      end
      if (load_sh) begin
        per_sh <= period_in;
        cmp_sh <= compare_in;
      end
      if (!one_pulse_en) begin
        op_run <= 1'b0;
      end else if (wrap) begin
        op_run <= 1'b0;
      end else if (trig_rise && !op_run) begin
        op_run <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmr_oc_refgen.sv
module tmr_oc_refgen
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              one_pulse_en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp_sh,
  input  logic              op_run,
  input  logic              step,
  output logic              oc_ref,
  output logic              match_hit
);

  logic ref_nxt;

  assign match_hit = step && (cnt == cmp_sh);

  always_comb begin
    ref_nxt = oc_ref;
    case (mode_in)
      OCM_TOGGLE: if (match_hit) ref_nxt = ~oc_ref;
      OCM_LOW:    ref_nxt = 1'b0;
      OCM_HIGH:   ref_nxt = 1'b1;
      OCM_PWMA:   ref_nxt = one_pulse_en ? pulse_level(op_run, 16'(cnt), 16'(cmp_sh))
                                         : pwm_a_level(16'(cnt), 16'(cmp_sh));
      default:    ref_nxt = oc_ref;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) oc_ref <= 1'b0;
    else     oc_ref <= ref_nxt;
  end

endmodule

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [CNT_W-1:0]  period_in,
  input  logic [CNT_W-1:0]  compare_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              one_pulse_en,
  input  logic              trig_in,
  output logic              oc_ref,
  output logic              upd_flag
);

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] per_sh_w;
  logic [CNT_W-1:0] cmp_sh_w;
  logic             run_w;
  logic             step_w;
  logic             match_w;

  tmr_oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .period_in    (period_in),
    .compare_in   (compare_in),
    .one_pulse_en (one_pulse_en),
    .trig_in      (trig_in),
    .cnt          (cnt_w),
    .per_sh       (per_sh_w),
    .cmp_sh       (cmp_sh_w),
    .op_run       (run_w),
    .step         (step_w),
    .wrap_q       (upd_flag)
  );

  tmr_oc_refgen #(.CNT_W(CNT_W)) u_ref (
    .clk          (clk),
    .rst          (rst),
    .mode_in      (mode_in),
    .one_pulse_en (one_pulse_en),
    .cnt          (cnt_w),
    .cmp_sh       (cmp_sh_w),
    .op_run       (run_w),
    .step         (step_w),
    .oc_ref       (oc_ref),
    .match_hit    (match_w)
  );

endmodule

// File: rtl/tmr_oc_channel_chk.sv
module tmr_oc_channel_chk
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic [MODE_W-1:0] mode_in,
  input logic              one_pulse_en,
  input logic              oc_ref,
  input logic              upd_flag,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per_sh,
  input logic [CNT_W-1:0]  cmp_sh,
  input logic              op_run,
  input logic              match_hit
);

  // R1: after a wrap the counter sits at zero
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    upd_flag |-> (cnt == '0));

  // R1: count never passes the active period
  a_r1_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_sh);

  // R2: no tick, no advance
  a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en) |=> $stable(cnt));

  // R3: toggle inverts on a match
  a_r3_toggle_flip: assert property (@(posedge clk) disable iff (rst)
    (mode_in == OCM_TOGGLE && match_hit) |=> (oc_ref != $past(oc_ref)));

  // R5: compare of zero keeps PWM A low
  a_r5_zero_low: assert property (@(posedge clk) disable iff (rst)
    (mode_in == OCM_PWMA && !one_pulse_en && cmp_sh == '0) |=> !oc_ref);

  // R7: parked one-pulse counter does not move
  a_r7_parked: assert property (@(posedge clk) disable iff (rst)
    (one_pulse_en && !op_run) |=> $stable(cnt));

  // R9: forced levels
  a_r9_force_low: assert property (@(posedge clk) disable iff (rst)
    (mode_in == OCM_LOW) |=> !oc_ref);
  a_r9_force_high: assert property (@(posedge clk) disable iff (rst)
    (mode_in == OCM_HIGH) |=> oc_ref);

  // R10: frozen mode holds the output
  a_r10_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_in == OCM_FROZEN) |=> $stable(oc_ref));

endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_en      (tick_en),
  .mode_in      (mode_in),
  .one_pulse_en (one_pulse_en),
  .oc_ref       (oc_ref),
  .upd_flag     (upd_flag),
  .cnt          (cnt_w),
  .per_sh       (per_sh_w),
  .cmp_sh       (cmp_sh_w),
  .op_run       (run_w),
  .match_hit    (match_w)
);

// File: tb/tmr_oc_channel_test.sv
module tmr_oc_channel_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en;
  logic [15:0] period_in = 16'd0;
  logic [15:0] compare_in = 16'd0;
  logic [2:0]  mode_in = 3'b000;
  logic        one_pulse_en = 1'b0;
  logic        trig_in = 1'b0;
  logic        oc_ref;
  logic        upd_flag;

  int n_cmp = 0;
  int n_bad = 0;
  int div = 0;
  int div_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_tag = "R11";

  always #10 clk = ~clk;  // 50 MHz

  tmr_oc_channel uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .period_in(period_in),
    .compare_in(compare_in), .mode_in(mode_in), .one_pulse_en(one_pulse_en),
    .trig_in(trig_in), .oc_ref(oc_ref), .upd_flag(upd_flag)
  );

  // prescale tick source
  initial tick_en = 1'b1;
  always @(negedge clk) begin
    if (div == 0) begin
      tick_en = 1'b1;
      div_cnt = 0;
    end else begin
      div_cnt = (div_cnt >= div) ? 0 : div_cnt + 1;
      tick_en = (div_cnt == 0);
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  typedef struct {
    logic  ref_v;
    logic  upd_v;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  int  m_cnt = 0, m_per = 0, m_cmp = 0;
  bit  m_run = 0, m_step = 0, m_ref = 0, m_upd = 0, m_trig = 0;

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_cnt = 0; m_per = 0; m_cmp = 0;
      m_run = 0; m_step = 0; m_ref = 0; m_upd = 0; m_trig = 0;
    end else begin
      bit free_run, moves, ends, r_new;
      r_new = m_ref;
      if (mode_in == 3'b100) r_new = 0;
      else if (mode_in == 3'b101) r_new = 1;
      else if (mode_in == 3'b011) begin
        if (m_step && m_cnt == m_cmp) r_new = !m_ref;
      end else if (mode_in == 3'b110) begin
        if (one_pulse_en) r_new = m_run && (m_cnt >= m_cmp);
        else r_new = (m_cnt < m_cmp);
      end
      free_run = !one_pulse_en || m_run;
      moves = tick_en && free_run;
      ends = moves && (m_cnt == m_per);
      m_ref = r_new;
      m_step = moves;
      m_upd = ends;
      if (moves) m_cnt = ends ? 0 : m_cnt + 1;
      if (ends || !free_run) begin
        m_per = int'(period_in);
        m_cmp = int'(compare_in);
      end
      if (!one_pulse_en || ends) m_run = 0;
      else if (trig_in && !m_trig) m_run = 1;
      m_trig = trig_in;
    end
    e.ref_v = m_ref;
    e.upd_v = m_upd;
    e.tag = rst ? "R11" : cur_tag;
    sb_q.push_back(e);
  end

  always @(negedge clk) begin
    cyc++;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, oc_ref, e.ref_v, "oc_ref");
      check(e.tag, upd_flag, e.upd_v, "upd_flag");
    end
  end

  // ---------------- driver ----------------
  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(string tag, int per, int cmp, logic [2:0] md, bit ope, int d);
    @(negedge clk);
    cur_tag = tag;
    period_in = 16'(per);
    compare_in = 16'(cmp);
    mode_in = md;
    one_pulse_en = ope;
    div = d;
  endtask

  // measure clocks between two upd_flag pulses
  task automatic measure(string tag, int exp_gap);
    int gap;
    gap = 0;
    while (!upd_flag) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!upd_flag && gap < 1000) begin
      @(negedge clk);
      gap++;
    end
    n_cmp++;
    if (gap != exp_gap) begin
      n_bad++;
      $display("FAIL %s update spacing: actual %0d expected %0d", tag, gap, exp_gap);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig_in = 1'b1;
    @(negedge clk) trig_in = 1'b0;
  endtask

  initial begin
    run(3);
    // R11: reset state at the ports
    check("R11", oc_ref, 1'b0, "reset oc_ref");
    check("R11", upd_flag, 1'b0, "reset upd_flag");
    rst = 1'b0;

    // R4: PWM A, period 9 compare 4, tick every clock
    setup("R4", 9, 4, 3'b110, 1'b0, 0);
    run(40);
    // R1: wrap spacing period+1
    measure("R1", 10);

    // R6: compare changes mid-cycle, applied at next wrap
    run(3);
    setup("R6", 9, 7, 3'b110, 1'b0, 0);
    run(15);
    setup("R6", 5, 7, 3'b110, 1'b0, 0);
    run(25);

    // R5: compare extremes
    setup("R5", 9, 0, 3'b110, 1'b0, 0);
    run(25);
    setup("R5", 9, 15, 3'b110, 1'b0, 0);
    run(25);

    // R3: toggle with a tick every third clock
    setup("R3", 9, 3, 3'b011, 1'b0, 2);
    run(70);
    // R2: spacing stretched by the prescale tick
    measure("R2", 30);

    // R9: forced levels
    setup("R9", 9, 3, 3'b100, 1'b0, 0);
    run(15);
    setup("R9", 9, 3, 3'b101, 1'b0, 0);
    run(15);

    // R10: frozen and unused codes hold
    setup("R10", 9, 3, 3'b000, 1'b0, 0);
    run(15);
    setup("R10", 9, 3, 3'b011, 1'b0, 0);
    run(14);
    setup("R10", 9, 3, 3'b010, 1'b0, 0);
    run(15);
    setup("R10", 9, 3, 3'b111, 1'b0, 0);
    run(15);
    setup("R10", 9, 3, 3'b001, 1'b0, 0);
    run(15);

    // R7: one-pulse, clean start from reset
    @(negedge clk) rst = 1'b1;
    setup("R7", 7, 3, 3'b110, 1'b1, 0);
    @(negedge clk) rst = 1'b0;
    run(15);
    pulse_trig();
    run(20);
    setup("R7", 7, 3, 3'b110, 1'b1, 1);
    pulse_trig();
    run(30);

    // R8: trigger during a running cycle, then with one-pulse off
    setup("R8", 7, 3, 3'b110, 1'b1, 0);
    pulse_trig();
    run(3);
    pulse_trig();
    run(20);
    setup("R8", 7, 3, 3'b110, 1'b0, 0);
    for (int k = 0; k < 4; k++) begin
      pulse_trig();
      run(3);
    end

    // R11: reset in the middle of a cycle
    setup("R11", 9, 5, 3'b011, 1'b0, 0);
    run(7);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R11", oc_ref, 1'b0, "mid-run reset oc_ref");
    check("R11", upd_flag, 1'b0, "mid-run reset upd_flag");
    rst = 1'b0;
    run(12);

    done = 1'b1;
  end

  // watchdog and summary
  initial begin
    int w;
    w = 0;
    while (!done && w < 100000) begin
      @(negedge clk);
      w++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule